// File: doc/BRIEF.md
# Single-Channel Memory-Mapped Copy Engine

This block is one DMA channel. Software programs a source address, a destination address and a byte count through a small register window. It then writes a configuration word whose top bit is set, and the channel starts moving data over a simple request/acknowledge memory bus. Each side of the copy has its own fields for data width, burst length, address stepping and request type. A side whose request type names a peripheral waits for that peripheral's request line before every burst. A side typed as memory runs freely.

Every beat is a read from the current source address followed by a write of the same word to the current destination address. The beat moves the narrower of the two programmed widths. The data travels in the low lanes of the bus word, with no byte-lane steering. The channel emits a one-cycle half-done pulse when at least half of the programmed bytes have been written. It emits a one-cycle done pulse when the last byte is written. Writing an all-zero configuration word stops a running channel at once. A zero byte count completes without touching the bus.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is idle, `bus_req`, `half_done` and `done` are low, and all four registers read zero.
- R2: Registers are decoded at full 4-bit offsets: 0x0 configuration, 0x4 source, 0x8 destination, 0xC byte count. Source and destination read back as written. Configuration reads back as written, except that bit 31 shows whether the channel is busy.
- R3: A configuration write with bit 31 set, made while idle, starts a transfer from the stored addresses and count. Bit 31 reads 1 while the transfer runs and 0 once it ends.
- R4: A beat reads the source and then writes the destination, carrying the read data into `bus_wdata`. A bus cycle completes only on a clock where `bus_req` and `bus_ack` are both high. Until then, `bus_req`, `bus_we` and `bus_addr` hold their values.
- R5: Width fields are destination 26:25 and source 10:9, with 0 meaning 1 byte, 1 meaning 2 bytes and 2 meaning 4 bytes. A beat moves the smaller of the two widths, and `bus_size` carries that code.
- R6: Address-mode fields are destination 22:21 and source 6:5. Value 0 advances the address by the beat size after each beat. Any other value keeps the address fixed.
- R7: Request-type fields are destination 20:16 and source 4:0. Value 0x16 means memory and needs no handshake. Any other value N requires `periph_req[N]` high before each burst starts. The burst length comes from the source field (8:7) when the source is a peripheral, and from the destination field (24:23) otherwise, with 0 meaning 1 beat, 1 meaning 4 beats and 2 meaning 8 beats.
- R8: When configuration bit 15 is set, the count register reads the bytes still to move. When bit 15 is clear, it reads the programmed count.
- R9: `half_done` pulses for one cycle, once per transfer, after the write beat that first brings the written bytes to at least half the count.
- R10: `done` pulses for one cycle after the final write beat. A start with count zero pulses `done` on the next cycle with no bus traffic.
- R11: Writing 0 to the configuration register while busy stops the channel on that edge. `bus_req` drops and no `done` follows.
- R12: While busy, every register write other than the all-zero configuration write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register read offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| bus_req | output | 1 | Memory bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Bus byte address |
| bus_size | output | 2 | Beat width code |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Bus acknowledge |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` on reads |
| periph_req | input | NUM_REQ | Peripheral request lines, indexed by request type |
| half_done | output | 1 | Midpoint pulse |
| done | output | 1 | Completion pulse |

## Verification
The sweep crosses every pairing of source and destination width with every combination of fixed and stepping address modes. A design that picked the wider width, or stepped a fixed port, would put the wrong address on a beat. A design that latched read data at the wrong time would write a stale word. The midpoint test catches a design that fires on the wrong beat or fires twice. The remaining-count readback is sampled in the middle of a transfer, which exposes a count that is decremented late or that reports the programmed value. Burst gating is tested by dropping the peripheral line exactly at a burst boundary; a design that checks only once per transfer would carry on. Halting, zero-count starts and writes made while busy are each followed by port-level observation for tens of cycles, to catch a stray `done`, a restarted bus or an overwritten register.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   localparam int WORD_W = 32;
   localparam logic [3:0] OFS_CFG = 4'h0;
   localparam logic [3:0] OFS_SRC = 4'h4;
   localparam logic [3:0] OFS_DST = 4'h8;
   localparam logic [3:0] OFS_CNT = 4'hC;
   localparam int LOAD_BIT   = 31;
   localparam int REMAIN_BIT = 15;

   typedef enum logic [1:0] {XS_IDLE, XS_GATE, XS_READ, XS_WRITE} xfer_state_e;

   typedef struct packed {
      logic [1:0] width;
      logic [1:0] burst;
      logic       fixed;
      logic [4:0] rtype;
   } side_cfg_t;

   function automatic side_cfg_t unpack_dst(input logic [WORD_W-1:0] w);
      side_cfg_t c;
      c.width = w[26:25];
      c.burst = w[24:23];
      c.fixed = |w[22:21];
      c.rtype = w[20:16];
      return c;
   endfunction

   function automatic side_cfg_t unpack_src(input logic [WORD_W-1:0] w);
      side_cfg_t c;
      c.width = w[10:9];
      c.burst = w[8:7];
      c.fixed = |w[6:5];
      c.rtype = w[4:0];
      return c;
   endfunction

   function automatic logic [3:0] burst_beats(input logic [1:0] enc);
      case (enc)
         2'd0:    return 4'd1;
         2'd1:    return 4'd4;
         default: return 4'd8;
      endcase
   endfunction

   function automatic logic [2:0] width_bytes(input logic [1:0] enc);
      case (enc)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [3:0]        rd_addr,
   input  logic              busy,
   input  logic [WORD_W-1:0] remaining,
   output logic              start,
   output logic              halt,
   output logic [WORD_W-1:0] src_q,
   output logic [WORD_W-1:0] dst_q,
   output logic [WORD_W-1:0] cnt_q,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] cfg_q;
   logic              cfg_sel;
   logic              accept;

   assign cfg_sel = wr_en && (wr_addr == OFS_CFG);
   assign halt    = cfg_sel && busy && (wr_data == '0);
   assign start   = cfg_sel && !busy && wr_data[LOAD_BIT];
   assign accept  = wr_en && (!busy || halt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         src_q <= '0;
         dst_q <= '0;
         cnt_q <= '0;
      end else if (accept) begin
         case (wr_addr)
            OFS_CFG: cfg_q <= wr_data;
            OFS_SRC: src_q <= wr_data;
            OFS_DST: dst_q <= wr_data;
            OFS_CNT: cnt_q <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         OFS_CFG: rd_data = {busy, cfg_q[LOAD_BIT-1:0]};
         OFS_SRC: rd_data = src_q;
         OFS_DST: rd_data = dst_q;
         OFS_CNT: rd_data = cfg_q[REMAIN_BIT] ? remaining : cnt_q;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/dma_chan_reqsel.sv
module dma_chan_reqsel #(
   parameter int         NUM_REQ   = 32,
   parameter logic [4:0] MEM_RTYPE = 5'h16
) (
   input  logic [NUM_REQ-1:0] periph_req,
   input  logic [4:0]         src_rtype,
   input  logic [4:0]         dst_rtype,
   output logic               gate_ok
);
   logic [31:0] lines;

   generate
      if (NUM_REQ == 32) begin : g_full
         assign lines = periph_req;
      end else begin : g_pad
         assign lines = {{(32-NUM_REQ){1'b0}}, periph_req};
      end
   endgenerate

   logic src_ok, dst_ok;
   assign src_ok  = (src_rtype == MEM_RTYPE) || lines[src_rtype];
   assign dst_ok  = (dst_rtype == MEM_RTYPE) || lines[dst_rtype];
   assign gate_ok = src_ok && dst_ok;
endmodule

// File: rtl/dma_chan_xfer.sv
module dma_chan_xfer
   import dma_chan_pkg::*;
#(
   parameter logic [4:0] MEM_RTYPE = 5'h16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              halt,
   input  logic [WORD_W-1:0] start_cfg,
   input  logic [WORD_W-1:0] src_base,
   input  logic [WORD_W-1:0] dst_base,
   input  logic [WORD_W-1:0] cnt_init,
   input  logic              gate_ok,
   input  logic              bus_ack,
   input  logic [WORD_W-1:0] bus_rdata,
   output logic              busy,
   output logic [WORD_W-1:0] remaining,
   output logic [4:0]        src_rtype,
   output logic [4:0]        dst_rtype,
   output logic              bus_req,
   output logic              bus_we,
   output logic [WORD_W-1:0] bus_addr,
   output logic [1:0]        bus_size,
   output logic [WORD_W-1:0] bus_wdata,
   output logic              half_done,
   output logic              done
);
   xfer_state_e       state;
   side_cfg_t         scfg, dcfg;
   logic [WORD_W-1:0] cur_src, cur_dst, total, hold;
   logic [3:0]        beats_left;
   logic              half_seen;

   logic [1:0]        narrow, step_enc;
   logic [WORD_W-1:0] step, sub, rem_next;
   logic [3:0]        burst_len;
   logic              crosses_half;

   assign narrow   = (scfg.width < dcfg.width) ? scfg.width : dcfg.width;
   assign step_enc = (narrow == 2'd3) ? 2'd2 : narrow;
   assign step     = {{(WORD_W-3){1'b0}}, width_bytes(step_enc)};
   assign sub      = (remaining < step) ? remaining : step;
   assign rem_next = remaining - sub;
   assign burst_len = (scfg.rtype != MEM_RTYPE) ? burst_beats(scfg.burst)
                                                : burst_beats(dcfg.burst);
   assign crosses_half = !half_seen && ({rem_next, 1'b0} <= {1'b0, total});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= XS_IDLE;
         scfg       <= '0;
         dcfg       <= '0;
         cur_src    <= '0;
         cur_dst    <= '0;
         total      <= '0;
         remaining  <= '0;
         hold       <= '0;
         beats_left <= '0;
         half_seen  <= 1'b0;
         half_done  <= 1'b0;
         done       <= 1'b0;
      end else begin
         half_done <= 1'b0;
         done      <= 1'b0;
         if (halt) begin
            state <= XS_IDLE;
         end else begin
            case (state)
               XS_IDLE: if (start) begin
                  scfg      <= unpack_src(start_cfg);
                  dcfg      <= unpack_dst(start_cfg);
                  cur_src   <= src_base;
                  cur_dst   <= dst_base;
                  total     <= cnt_init;
                  remaining <= cnt_init;
                  half_seen <= 1'b0;
                  if (cnt_init == '0) done  <= 1'b1;
                  else                state <= XS_GATE;
               end
               XS_GATE: if (gate_ok) begin
                  beats_left <= burst_len;
                  state      <= XS_READ;
               end
               XS_READ: if (bus_ack) begin
                  hold  <= bus_rdata;
                  state <= XS_WRITE;
               end
               XS_WRITE: if (bus_ack) begin
                  remaining  <= rem_next;
                  beats_left <= beats_left - 4'd1;
                  if (!scfg.fixed) cur_src <= cur_src + step;
                  if (!dcfg.fixed) cur_dst <= cur_dst + step;
                  if (crosses_half) begin
                     half_done <= 1'b1;
                     half_seen <= 1'b1;
                  end
                  if (rem_next == '0) begin
                     done  <= 1'b1;
                     state <= XS_IDLE;
                  end else if (beats_left == 4'd1) begin
                     state <= XS_GATE;
                  end else begin
                     state <= XS_READ;
                  end
               end
               default: state <= XS_IDLE;
            endcase
         end
      end
   end

   assign busy      = (state != XS_IDLE);
   assign bus_req   = (state == XS_READ) || (state == XS_WRITE);
   assign bus_we    = (state == XS_WRITE);
   assign bus_addr  = bus_we ? cur_dst : cur_src;
   assign bus_size  = step_enc;
   assign bus_wdata = hold;
   assign src_rtype = scfg.rtype;
   assign dst_rtype = dcfg.rtype;
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
   import dma_chan_pkg::*;
#(
   parameter int         NUM_REQ   = 32,
   parameter logic [4:0] MEM_RTYPE = 5'h16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr_en,
   input  logic [3:0]         reg_wr_addr,
   input  logic [31:0]        reg_wr_data,
   input  logic [3:0]         reg_rd_addr,
   output logic [31:0]        reg_rd_data,
   output logic               bus_req,
   output logic               bus_we,
   output logic [31:0]        bus_addr,
   output logic [1:0]         bus_size,
   output logic [31:0]        bus_wdata,
   input  logic               bus_ack,
   input  logic [31:0]        bus_rdata,
   input  logic [NUM_REQ-1:0] periph_req,
   output logic               half_done,
   output logic               done
);
   generate
      if (NUM_REQ < 1 || NUM_REQ > 32) begin : g_bad_num_req
         $error("NUM_REQ must lie in 1..32");
      end
      if (WORD_W != 32) begin : g_bad_word
         $error("register word must be 32 bits");
      end
   endgenerate

   logic              busy, start, halt, gate_ok;
   logic [31:0]       remaining, src_q, dst_q, cnt_q;
   logic [4:0]        src_rtype, dst_rtype;

   dma_chan_regs i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wr_addr   (reg_wr_addr),
      .wr_data   (reg_wr_data),
      .rd_addr   (reg_rd_addr),
      .busy      (busy),
      .remaining (remaining),
      .start     (start),
      .halt      (halt),
      .src_q     (src_q),
      .dst_q     (dst_q),
      .cnt_q     (cnt_q),
      .rd_data   (reg_rd_data)
   );

   dma_chan_reqsel #(.NUM_REQ(NUM_REQ), .MEM_RTYPE(MEM_RTYPE)) i_reqsel (
      .periph_req (periph_req),
      .src_rtype  (src_rtype),
      .dst_rtype  (dst_rtype),
      .gate_ok    (gate_ok)
   );

   dma_chan_xfer #(.MEM_RTYPE(MEM_RTYPE)) i_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .halt      (halt),
      .start_cfg (reg_wr_data),
      .src_base  (src_q),
      .dst_base  (dst_q),
      .cnt_init  (cnt_q),
      .gate_ok   (gate_ok),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata),
      .busy      (busy),
      .remaining (remaining),
      .src_rtype (src_rtype),
      .dst_rtype (dst_rtype),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wdata (bus_wdata),
      .half_done (half_done),
      .done      (done)
   );
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr_en,
   input logic [3:0]  reg_wr_addr,
   input logic [31:0] reg_wr_data,
   input logic        bus_req,
   input logic        bus_ack,
   input logic        bus_we,
   input logic [31:0] bus_addr,
   input logic        half_done,
   input logic        done,
   input logic        busy,
   input logic [31:0] remaining
);
   logic halt_w;
   assign halt_w = reg_wr_en && (reg_wr_addr == 4'h0) && (reg_wr_data == 32'h0);

   // R1: an idle channel never requests the bus
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);

   // R4: request, direction and address hold until acknowledged
   a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack && !halt_w) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   // R9: midpoint event is a single-cycle pulse
   a_r9_half_single: assert property (@(posedge clk) disable iff (!rst_n)
      half_done |=> !half_done);

   // R10: completion is a single-cycle pulse with nothing left to move
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (remaining == 32'h0));

   // R11: halting zero write stops the channel on that edge
   a_r11_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_w && busy) |=> (!busy && !bus_req && !done));
endmodule

bind dma_chan_engine dma_chan_checker i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_en   (reg_wr_en),
   .reg_wr_addr (reg_wr_addr),
   .reg_wr_data (reg_wr_data),
   .bus_req     (bus_req),
   .bus_ack     (bus_ack),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .half_done   (half_done),
   .done        (done),
   .busy        (busy),
   .remaining   (remaining)
);

// File: tb/test_dma_chan_engine.sv
module test_dma_chan_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [3:0]  reg_wr_addr = 4'h0;
   logic [31:0] reg_wr_data = 32'h0;
   logic [3:0]  reg_rd_addr = 4'h0;
   logic [31:0] reg_rd_data;
   logic        bus_req, bus_we;
   logic [31:0] bus_addr, bus_wdata;
   logic [1:0]  bus_size;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = 32'h0;
   logic [31:0] periph_req = 32'h0;
   logic        half_done, done;

   always #4 clk = ~clk;

   dma_chan_engine i_dma_chan_engine (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .periph_req(periph_req), .half_done(half_done), .done(done)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pattern(input logic [31:0] a);
      return a ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [31:0] mkcfg(input int sw, input int sb, input int sm, input int st,
                                         input int dw, input int db, input int dm, input int dt,
                                         input bit rem);
      logic [31:0] w = 32'h8000_0000;
      w[26:25] = 2'(dw); w[24:23] = 2'(db); w[22:21] = 2'(dm); w[20:16] = 5'(dt);
      w[15]    = rem;
      w[10:9]  = 2'(sw); w[8:7]   = 2'(sb); w[6:5]   = 2'(sm); w[4:0]   = 5'(st);
      return w;
   endfunction

   // bus responder and beat monitor
   int          ack_lat = 0;
   int          wait_cnt = 0;
   bit          mon_en = 0;
   bit          hs_pending = 0, hs_we = 0;
   logic [31:0] hs_addr, hs_wdata;
   logic [1:0]  hs_size;
   logic [31:0] last_rd = 0;
   int          beat_k = 0;
   bit          half_got = 0;
   int          done_count = 0;
   int          exp_cnt, exp_step;
   logic [1:0]  exp_size;
   bit          exp_sfix, exp_dfix;
   logic [31:0] exp_src, exp_dst;

   always @(negedge clk) begin
      bit eh, ed;
      eh = 0; ed = 0;
      if (mon_en) begin
         if (hs_pending && !hs_we) begin
            chk(hs_addr == exp_src + (exp_sfix ? 0 : beat_k*exp_step), "R6 source address",
                hs_addr, exp_src + (exp_sfix ? 0 : beat_k*exp_step));
            chk(hs_size == exp_size, "R5 beat size", 32'(hs_size), 32'(exp_size));
            last_rd = hs_addr;
         end else if (hs_pending && hs_we) begin
            chk(hs_addr == exp_dst + (exp_dfix ? 0 : beat_k*exp_step), "R6 destination address",
                hs_addr, exp_dst + (exp_dfix ? 0 : beat_k*exp_step));
            chk(hs_wdata == pattern(last_rd), "R4 write data", hs_wdata, pattern(last_rd));
            beat_k++;
            eh = !half_got && (beat_k*exp_step*2 >= exp_cnt);
            if (eh) half_got = 1;
            ed = (beat_k*exp_step >= exp_cnt);
         end
         chk(half_done == eh, "R9 half_done", 32'(half_done), 32'(eh));
         chk(done == ed, "R10 done", 32'(done), 32'(ed));
      end
      if (done) done_count++;
      hs_pending = 0;
      if (bus_req && !bus_ack) begin
         if (wait_cnt >= ack_lat) begin
            bus_ack = 1; wait_cnt = 0;
            bus_rdata = pattern(bus_addr);
            hs_pending = 1; hs_we = bus_we; hs_addr = bus_addr;
            hs_wdata = bus_wdata; hs_size = bus_size;
         end else wait_cnt++;
      end else bus_ack = 0;
   end

   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk); reg_wr_en = 0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
      reg_rd_addr = a; #1; d = reg_rd_data;
   endtask

   task automatic arm(input int sw, input int dw, input int sm, input int dm, input int cnt,
                      input logic [31:0] s, input logic [31:0] d);
      int n = (sw < dw) ? sw : dw;
      exp_cnt = cnt; exp_size = 2'(n); exp_step = 1 << n;
      exp_sfix = (sm != 0); exp_dfix = (dm != 0);
      exp_src = s; exp_dst = d; beat_k = 0; half_got = 0;
      reg_write(4'h4, s); reg_write(4'h8, d); reg_write(4'hC, 32'(cnt));
      mon_en = 1;
   endtask

   task automatic wait_done(input int start_cnt);
      for (int i = 0; i < 4000 && done_count == start_cnt; i++) @(negedge clk);
      #1; mon_en = 0;
      chk(done_count == start_cnt + 1, "R10 transfer completes", 32'(done_count), 32'(start_cnt+1));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int dc;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 16; a += 4) begin
         reg_read(4'(a), rd); chk(rd == 0, "R1 register reset", rd, 0);
      end
      chk(!bus_req && !done && !half_done, "R1 outputs idle", {bus_req, done, half_done}, 0);

      // R2/R3/R5/R6/R8 sweep: widths x address modes, memory to memory
      for (int sw = 0; sw < 3; sw++)
         for (int dw = 0; dw < 3; dw++)
            for (int m = 0; m < 4; m++) begin
               logic [31:0] cfg, s, d;
               s = 32'h1000_0000 + 32'(sw*256 + dw*64 + m*16);
               d = 32'h2000_0000 + 32'(m*512);
               cfg = mkcfg(sw, sw % 3, (m & 1) ? 1 : 0, 'h16, dw, dw % 3, (m & 2) ? 3 : 0, 'h16, m[0]);
               ack_lat = (sw + dw + m) % 3;
               arm(sw, dw, m & 1, m & 2, 24, s, d);
               dc = done_count;
               reg_write(4'h0, cfg);
               reg_read(4'h0, rd); chk(rd[31] == 1'b1, "R3 busy reads 1", rd, cfg);
               wait_done(dc);
               chk(beat_k * exp_step == 24, "R5 beat count", 32'(beat_k), 32'(24 / exp_step));
               reg_read(4'h0, rd); chk(rd == (cfg & 32'h7FFF_FFFF), "R3 load bit clears", rd, cfg & 32'h7FFF_FFFF);
               reg_read(4'h4, rd); chk(rd == s, "R2 source readback", rd, s);
               reg_read(4'hC, rd); chk(rd == (m[0] ? 0 : 24), "R8 count readback", rd, m[0] ? 0 : 24);
            end

      // R8 remaining count mid-transfer
      ack_lat = 6;
      arm(2, 2, 0, 0, 32, 32'h3000_0000, 32'h3100_0000);
      dc = done_count;
      reg_write(4'h0, mkcfg(2, 2, 0, 'h16, 2, 2, 0, 'h16, 1));
      wait (beat_k == 3); #2;
      reg_read(4'hC, rd); chk(rd == 20, "R8 remaining mid-transfer", rd, 20);
      // R12 writes while busy are ignored
      reg_write(4'h4, 32'hDEAD_0000);
      reg_write(4'hC, 32'd4);
      reg_write(4'h0, 32'h8000_0016);
      wait_done(dc);
      chk(beat_k == 8, "R12 count unchanged by busy write", 32'(beat_k), 8);
      reg_read(4'h4, rd); chk(rd == 32'h3000_0000, "R12 source unchanged", rd, 32'h3000_0000);
      reg_read(4'h0, rd); chk(rd == (mkcfg(2,2,0,'h16,2,2,0,'h16,1) & 32'h7FFF_FFFF), "R12 config unchanged", rd, 0);

      // R7 peripheral handshake gates each burst
      ack_lat = 0;
      periph_req = 32'h0;
      arm(2, 2, 0, 1, 32, 32'h4000_0000, 32'h4100_0000);
      dc = done_count;
      reg_write(4'h0, mkcfg(2, 0, 0, 'h16, 2, 1, 1, 5, 1));
      begin
         int seen = 0;
         for (int i = 0; i < 20; i++) begin @(negedge clk); #1; if (bus_req) seen++; end
         chk(seen == 0, "R7 waits for peripheral line", 32'(seen), 0);
      end
      periph_req[5] = 1'b1;
      wait (beat_k == 4);
      periph_req[5] = 1'b0;
      begin
         int seen = 0;
         for (int i = 0; i < 20; i++) begin @(negedge clk); #1; if (bus_req) seen++; end
         chk(seen == 0 && beat_k == 4, "R7 gate at burst boundary", 32'(beat_k), 4);
      end
      periph_req[5] = 1'b1;
      wait_done(dc);
      periph_req = 32'h0;

      // R10 zero count
      reg_write(4'hC, 32'd0);
      dc = done_count;
      reg_write(4'h0, mkcfg(2, 0, 0, 'h16, 2, 0, 0, 'h16, 0));
      #1;
      chk(done == 1'b1, "R10 zero count done", 32'(done), 1);
      chk(bus_req == 1'b0, "R10 zero count no traffic", 32'(bus_req), 0);
      @(negedge clk); #1;
      chk(done == 1'b0 && bus_req == 1'b0, "R10 zero count single pulse", {done, bus_req}, 0);

      // R11 halt mid-transfer
      ack_lat = 1;
      reg_write(4'h4, 32'h5000_0000); reg_write(4'h8, 32'h5100_0000); reg_write(4'hC, 32'd64);
      reg_write(4'h0, mkcfg(0, 0, 0, 'h16, 0, 0, 0, 'h16, 1));
      repeat (10) @(negedge clk);
      dc = done_count;
      reg_write(4'h0, 32'h0);
      #1;
      chk(bus_req == 1'b0, "R11 halt drops request", 32'(bus_req), 0);
      reg_read(4'h0, rd); chk(rd == 32'h0, "R11 config reads idle", rd, 0);
      begin
         int seen = 0;
         for (int i = 0; i < 20; i++) begin @(negedge clk); #1; if (bus_req) seen++; end
         chk(seen == 0 && done_count == dc, "R11 no done after halt", 32'(done_count), 32'(dc));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule